// File: doc/BRIEF.md
# Per-Tap Adaptation Step Profile Generator

This block gives an adaptive echo-cancelling filter a step size for each of its taps. A start pulse loads the configuration. The block then walks the tap index upward from zero, one tap per clock cycle, to the last tap of the selected filter length. For each tap it presents a step-size exponent with a valid strobe. A larger exponent means a smaller step, since the step equals 2 to the minus exponent. The coefficient-update logic consumes this exponent stream, tap by tap.

The profile has three regions. The first taps model the bulk transmission delay and are held at a fixed small step. The taps after them use a nominal exponent supplied by the caller. The taps near the end of the filter form a tail in which the step halves at fixed tap intervals. The caller sets the length of the delay region, the tail interval size, the number of tail intervals and the nominal exponent through input fields.

Top module: `mu_profile_gen`

## Requirements
- R1: After reset, `tap_valid` and `done` are both low and stay low until a start pulse is accepted.
- R2: A start pulse seen while idle is accepted. From the next cycle, `tap_valid` is high for exactly L consecutive cycles, with `tap_idx` running 0, 1, ..., L-1. L is 512 when `len_long`=0 and 1024 when `len_long`=1.
- R3: Every tap with index below 8 × `flat_cfg` outputs `mu_exp` = 16.
- R4: `flat_cfg` is limited to 64 when `ext_delay`=0 and to 128 when `ext_delay`=1. A larger value acts as the limit.
- R5: Taps that are outside the flat region and below the decay start D output `mu_exp` = `nom_exp`.
- R6: With SS = 4 × 2^`step_cfg` and D = L − `nsteps_cfg` × SS, each tap t ≥ D outside the flat region outputs `nom_exp` + 1 + floor((t − D) / SS).
- R7: When `nsteps_cfg` × SS ≥ L, D is 0, so the tail starts at tap 0. The flat region still takes priority over the tail.
- R8: The tail exponent saturates at 31 and never wraps.
- R9: `done` is high for exactly one cycle: the cycle after the last tap, in which `tap_valid` is low.
- R10: All inputs are sampled only when a start is accepted. Field changes and start pulses during a sweep do not change that sweep's output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a sweep (ignored while busy) |
| len_long | input | 1 | Filter length select: 0 = 512 taps, 1 = 1024 taps |
| ext_delay | input | 1 | Extended delay mode: raises the flat-length limit |
| flat_cfg | input | 8 | Flat region length in units of 8 taps |
| step_cfg | input | 3 | Tail interval control; SS = 4 × 2^step_cfg |
| nsteps_cfg | input | 8 | Number of tail intervals |
| nom_exp | input | 5 | Nominal step exponent |
| tap_valid | output | 1 | Tap index and exponent are valid |
| tap_idx | output | 10 | Current tap index |
| mu_exp | output | 5 | Step exponent for the current tap |
| done | output | 1 | One-cycle end-of-sweep pulse |

## Verification
The start pulse is registered on a clock edge, and tap 0 appears on the outputs right after that edge. Each later tap follows one edge after the one before it, and `done` appears one edge after tap L−1. The bench computes every expected tap and the final done marker from the requirement formulas and queues them before it raises start. A monitor samples on the falling clock edge, halfway between active edges, and takes one queued item for each cycle in which `tap_valid` or `done` is high. This makes any missing, extra or early output show up as a mismatch at the exact cycle where it occurs.

// File: rtl/mu_prof_pkg.sv
package mu_prof_pkg;

   // Field widths of the configuration inputs
   localparam int FD_W  = 8;
   localparam int SSC_W = 3;
   localparam int NS_W  = 8;
   localparam int EXP_W = 5;

   // Configuration snapshot held for one sweep
   typedef struct packed {
      logic             len_long;
      logic [FD_W-1:0]  fd_eff;
      logic [SSC_W-1:0] ssc;
      logic [NS_W-1:0]  ns;
      logic [EXP_W-1:0] nom;
   } sweep_cfg_t;

endpackage

// File: rtl/mu_cfg_latch.sv
module mu_cfg_latch
   import mu_prof_pkg::*;
#(
   parameter int FD_MAX_NORM = 64,
   parameter int FD_MAX_EXT  = 128
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             accept,
   input  logic             len_long,
   input  logic             ext_delay,
   input  logic [FD_W-1:0]  flat_cfg,
   input  logic [SSC_W-1:0] step_cfg,
   input  logic [NS_W-1:0]  nsteps_cfg,
   input  logic [EXP_W-1:0] nom_exp,
   output sweep_cfg_t       cfg_q
);

   localparam logic [FD_W-1:0] LIM_N = FD_W'(FD_MAX_NORM);
   localparam logic [FD_W-1:0] LIM_E = FD_W'(FD_MAX_EXT);

   logic [FD_W-1:0] fd_lim;
   logic [FD_W-1:0] fd_clamped;

   always_comb begin
      fd_lim     = ext_delay ? LIM_E : LIM_N;
      fd_clamped = (flat_cfg > fd_lim) ? fd_lim : flat_cfg;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0;
      end else if (accept) begin
         cfg_q.len_long <= len_long;
         cfg_q.fd_eff   <= fd_clamped;
         cfg_q.ssc      <= step_cfg;
         cfg_q.ns       <= nsteps_cfg;
         cfg_q.nom      <= nom_exp;
      end
   end

endmodule

// File: rtl/mu_tap_seq.sv
module mu_tap_seq #(
   parameter int SHORT_LEN = 512,
   parameter int LONG_LEN  = 1024,
   parameter int TAP_W     = $clog2(LONG_LEN)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             len_long_q,
   output logic             accept,
   output logic             busy,
   output logic [TAP_W-1:0] tap,
   output logic             done
);

   localparam logic [TAP_W-1:0] LAST_S = TAP_W'(SHORT_LEN - 1);
   localparam logic [TAP_W-1:0] LAST_L = TAP_W'(LONG_LEN - 1);

   logic [TAP_W-1:0] last_tap;
   logic             at_last;

   always_comb begin
      accept   = start && !busy;
      last_tap = len_long_q ? LAST_L : LAST_S;
      at_last  = (tap == last_tap);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy <= 1'b0;
         tap  <= '0;
         done <= 1'b0;
      end else begin
         done <= 1'b0;
         if (accept) begin
            busy <= 1'b1;
            tap  <= '0;
         end else if (busy) begin
            if (at_last) begin
               busy <= 1'b0;
               done <= 1'b1;
            end else begin
               tap <= tap + 1'b1;
            end
         end
      end
   end

endmodule

// File: rtl/mu_region_calc.sv
module mu_region_calc
   import mu_prof_pkg::*;
#(
   parameter int SHORT_LEN = 512,
   parameter int LONG_LEN  = 1024,
   parameter int FLAT_EXP  = 16,
   parameter int TAP_W     = $clog2(LONG_LEN)
) (
   input  sweep_cfg_t       cfg,
   input  logic [TAP_W-1:0] tap,
   output logic [EXP_W-1:0] mu
);

   localparam int SH_MAX = (2**SSC_W - 1) + 2;
   localparam int SPAN_W = NS_W + SH_MAX;
   localparam int CW0    = (SPAN_W > TAP_W + 1) ? SPAN_W : TAP_W + 1;
   localparam int CMP_W  = ((CW0 > FD_W + 3) ? CW0 : FD_W + 3) + 1;
   localparam int MAX_EXP = 2**EXP_W - 1;

   localparam logic [CMP_W-1:0] LEN_S = CMP_W'(SHORT_LEN);
   localparam logic [CMP_W-1:0] LEN_L = CMP_W'(LONG_LEN);

   logic [CMP_W-1:0] len_c;
   logic [CMP_W-1:0] span;
   logic [CMP_W-1:0] decay_start;
   logic [CMP_W-1:0] flat_end;
   logic [CMP_W-1:0] tap_c;
   logic [CMP_W-1:0] steps;
   logic [CMP_W-1:0] sum;
   logic [4:0]       shamt;

   always_comb begin
      shamt       = 5'(cfg.ssc) + 5'd2;
      len_c       = cfg.len_long ? LEN_L : LEN_S;
      span        = CMP_W'(cfg.ns) << shamt;
      decay_start = (span >= len_c) ? '0 : (len_c - span);
      flat_end    = CMP_W'(cfg.fd_eff) << 3;
      tap_c       = CMP_W'(tap);
      steps       = (tap_c - decay_start) >> shamt;
      sum         = CMP_W'(cfg.nom) + CMP_W'(1) + steps;
      if (tap_c < flat_end)
         mu = EXP_W'(FLAT_EXP);
      else if (tap_c < decay_start)
         mu = cfg.nom;
      else if (sum > CMP_W'(MAX_EXP))
         mu = EXP_W'(MAX_EXP);
      else
         mu = sum[EXP_W-1:0];
   end

endmodule

// File: rtl/mu_profile_gen.sv
module mu_profile_gen
   import mu_prof_pkg::*;
#(
   parameter int SHORT_LEN   = 512,
   parameter int LONG_LEN    = 1024,
   parameter int FLAT_EXP    = 16,
   parameter int FD_MAX_NORM = 64,
   parameter int FD_MAX_EXT  = 128,
   parameter bit OUT_REG     = 1'b0,
   parameter int TAP_W       = $clog2(LONG_LEN)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic             len_long,
   input  logic             ext_delay,
   input  logic [7:0]       flat_cfg,
   input  logic [2:0]       step_cfg,
   input  logic [7:0]       nsteps_cfg,
   input  logic [4:0]       nom_exp,
   output logic             tap_valid,
   output logic [TAP_W-1:0] tap_idx,
   output logic [4:0]       mu_exp,
   output logic             done
);

   // Elaboration-time parameter checks
   if (FLAT_EXP > 2**EXP_W - 1) begin : g_bad_flat
      $error("FLAT_EXP does not fit the exponent width");
   end
   if (SHORT_LEN >= LONG_LEN || LONG_LEN > 2**TAP_W) begin : g_bad_len
      $error("length parameters inconsistent with TAP_W");
   end
   if (FD_MAX_EXT > 2**FD_W - 1 || FD_MAX_NORM > FD_MAX_EXT) begin : g_bad_fd
      $error("flat delay limits out of range");
   end

   sweep_cfg_t       cfg_q;
   logic             accept;
   logic             busy;
   logic [TAP_W-1:0] tap;
   logic             seq_done;
   logic [EXP_W-1:0] mu_c;

   mu_cfg_latch #(
      .FD_MAX_NORM (FD_MAX_NORM),
      .FD_MAX_EXT  (FD_MAX_EXT)
   ) u_cfg (
      .clk        (clk),
      .rst_n      (rst_n),
      .accept     (accept),
      .len_long   (len_long),
      .ext_delay  (ext_delay),
      .flat_cfg   (flat_cfg),
      .step_cfg   (step_cfg),
      .nsteps_cfg (nsteps_cfg),
      .nom_exp    (nom_exp),
      .cfg_q      (cfg_q)
   );

   mu_tap_seq #(
      .SHORT_LEN (SHORT_LEN),
      .LONG_LEN  (LONG_LEN),
      .TAP_W     (TAP_W)
   ) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .len_long_q (cfg_q.len_long),
      .accept     (accept),
      .busy       (busy),
      .tap        (tap),
      .done       (seq_done)
   );

   mu_region_calc #(
      .SHORT_LEN (SHORT_LEN),
      .LONG_LEN  (LONG_LEN),
      .FLAT_EXP  (FLAT_EXP),
      .TAP_W     (TAP_W)
   ) u_calc (
      .cfg (cfg_q),
      .tap (tap),
      .mu  (mu_c)
   );

   if (OUT_REG) begin : g_out_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            tap_valid <= 1'b0;
            tap_idx   <= '0;
            mu_exp    <= '0;
            done      <= 1'b0;
         end else begin
            tap_valid <= busy;
            tap_idx   <= tap;
            mu_exp    <= mu_c;
            done      <= seq_done;
         end
      end
   end else begin : g_out_comb
      always_comb begin
         tap_valid = busy;
         tap_idx   = tap;
         mu_exp    = mu_c;
         done      = seq_done;
      end
   end

endmodule

// File: rtl/mu_profile_chk.sv
module mu_profile_chk #(
   parameter int FLAT_EXP    = 16,
   parameter int FD_MAX_NORM = 64,
   parameter int FD_MAX_EXT  = 128,
   parameter int TAP_W       = 10
) (
   input logic             clk,
   input logic             rst_n,
   input logic             start,
   input logic             ext_delay,
   input logic [7:0]       flat_cfg,
   input logic             tap_valid,
   input logic [TAP_W-1:0] tap_idx,
   input logic [4:0]       mu_exp,
   input logic             done
);

   int fd_hold;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         fd_hold <= 0;
      else if (start && !tap_valid)
         fd_hold <= ext_delay ? ((int'(flat_cfg) > FD_MAX_EXT) ? FD_MAX_EXT : int'(flat_cfg))
                              : ((int'(flat_cfg) > FD_MAX_NORM) ? FD_MAX_NORM : int'(flat_cfg));
   end

   p_first_tap_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tap_valid) |-> tap_idx == '0);

   p_idx_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
      tap_valid |=> (!tap_valid || tap_idx == $past(tap_idx) + 1'b1));

   p_flat_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (tap_valid && int'(tap_idx) < fd_hold * 8) |-> int'(mu_exp) == FLAT_EXP);

   p_done_alone_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !tap_valid);

   p_done_after_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tap_valid) |-> done);

   p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

endmodule

bind mu_profile_gen mu_profile_chk #(
   .FLAT_EXP    (FLAT_EXP),
   .FD_MAX_NORM (FD_MAX_NORM),
   .FD_MAX_EXT  (FD_MAX_EXT),
   .TAP_W       (TAP_W)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .start     (start),
   .ext_delay (ext_delay),
   .flat_cfg  (flat_cfg),
   .tap_valid (tap_valid),
   .tap_idx   (tap_idx),
   .mu_exp    (mu_exp),
   .done      (done)
);

// File: tb/mu_profile_gen_test.sv
`timescale 1ns/1ps
module mu_profile_gen_test;

   typedef struct {
      bit    is_done;
      int    idx;
      int    mu;
      string req;
   } item_t;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       start = 1'b0;
   logic       len_long = 1'b0;
   logic       ext_delay = 1'b0;
   logic [7:0] flat_cfg = '0;
   logic [2:0] step_cfg = '0;
   logic [7:0] nsteps_cfg = '0;
   logic [4:0] nom_exp = '0;
   logic       tap_valid;
   logic [9:0] tap_idx;
   logic [4:0] mu_exp;
   logic       done;

   int    checks = 0;
   int    errors = 0;
   item_t exp_q[$];
   bit    finished = 0;

   always #2.5 clk = ~clk;

   mu_profile_gen uut (
      .clk        (clk),
      .rst_n      (rst_n),
      .start      (start),
      .len_long   (len_long),
      .ext_delay  (ext_delay),
      .flat_cfg   (flat_cfg),
      .step_cfg   (step_cfg),
      .nsteps_cfg (nsteps_cfg),
      .nom_exp    (nom_exp),
      .tap_valid  (tap_valid),
      .tap_idx    (tap_idx),
      .mu_exp     (mu_exp),
      .done       (done)
   );

   // Expected exponent computed from the requirement formulas
   function automatic int model_mu(int tap, int len, int fd, bit ext, int ssc, int ns, int nom);
      int fdc, ss, span, ds, v;
      fdc  = ext ? ((fd > 128) ? 128 : fd) : ((fd > 64) ? 64 : fd);
      if (tap < fdc * 8) return 16;
      ss   = 4 << ssc;
      span = ns * ss;
      ds   = (span >= len) ? 0 : len - span;
      if (tap < ds) return nom;
      v = nom + 1 + (tap - ds) / ss;
      return (v > 31) ? 31 : v;
   endfunction

   function automatic string region_tag(int tap, int len, int fd, bit ext, int ssc, int ns, int nom);
      int fdc, span, ds, v;
      fdc  = ext ? ((fd > 128) ? 128 : fd) : ((fd > 64) ? 64 : fd);
      if (tap < fdc * 8) return "R3";
      span = ns * (4 << ssc);
      ds   = (span >= len) ? 0 : len - span;
      if (tap < ds) return "R5";
      v = model_mu(tap, len, fd, ext, ssc, ns, nom);
      return (v == 31) ? "R8" : "R6";
   endfunction

   task automatic check(bit ok, string req, string what, int act, int expv);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
      end
   endtask

   // Driver: queue the whole expected sweep, then pulse start
   task automatic run_sweep(bit ll, bit ex, int fd, int ssc, int ns, int nom,
                            bit disturb, string tag);
      int    len;
      item_t it;
      len = ll ? 1024 : 512;
      for (int t = 0; t < len; t++) begin
         it.is_done = 0;
         it.idx     = t;
         it.mu      = model_mu(t, len, fd, ex, ssc, ns, nom);
         it.req     = (tag != "") ? tag : region_tag(t, len, fd, ex, ssc, ns, nom);
         exp_q.push_back(it);
      end
      it.is_done = 1;
      it.idx     = 0;
      it.mu      = 0;
      it.req     = "R9";
      exp_q.push_back(it);
      @(negedge clk);
      len_long   = ll;
      ext_delay  = ex;
      flat_cfg   = 8'(fd);
      step_cfg   = 3'(ssc);
      nsteps_cfg = 8'(ns);
      nom_exp    = 5'(nom);
      start      = 1'b1;
      @(negedge clk);
      start = 1'b0;
      if (disturb) begin
         // R10: new fields and a fresh start mid-sweep must not matter
         repeat (4) @(negedge clk);
         len_long   = ~ll;
         ext_delay  = ~ex;
         flat_cfg   = 8'd3;
         step_cfg   = 3'd0;
         nsteps_cfg = 8'd250;
         nom_exp    = 5'd2;
         start      = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      while (exp_q.size() != 0) @(negedge clk);
      repeat (2) @(negedge clk);
   endtask

   // Monitor: one queued item per output cycle, sampled mid-period
   always @(negedge clk) begin
      if (rst_n && !finished && (tap_valid || done)) begin
         if (tap_valid && done) begin
            check(0, "R9", "done with tap_valid", 1, 0);
         end else if (exp_q.size() == 0) begin
            check(0, "R2", "output with nothing expected", int'(tap_idx), -1);
         end else begin
            item_t it;
            it = exp_q.pop_front();
            if (it.is_done) begin
               check(done, it.req, "done pulse after last tap", int'(done), 1);
            end else begin
               check(tap_valid && int'(tap_idx) == it.idx, "R2", "tap index",
                     int'(tap_idx), it.idx);
               check(int'(mu_exp) == it.mu, it.req, "mu exponent",
                     int'(mu_exp), it.mu);
            end
         end
      end
   end

   // Watchdog
   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         check(0, "R2", "watchdog expired", 0, 1);
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: idle outputs under and after reset
      check(tap_valid == 1'b0 && done == 1'b0, "R1", "outputs in reset",
            int'(tap_valid) + int'(done), 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check(tap_valid == 1'b0 && done == 1'b0, "R1", "idle after reset",
            int'(tap_valid) + int'(done), 0);

      // Three regions, short filter: flat 0..39, nominal to 255, tail from 256
      run_sweep(1'b0, 1'b0, 5, 4, 4, 10, 1'b0, "");
      // R4: normal mode limit 64 -> 512 flat taps of 1024, no tail
      run_sweep(1'b1, 1'b0, 70, 2, 0, 20, 1'b0, "R4");
      // R4: extended mode limit 128 -> whole long filter flat
      run_sweep(1'b1, 1'b1, 200, 1, 5, 7, 1'b0, "R4");
      // R2: long filter, extended flat 800 taps, tail starts at 976
      run_sweep(1'b1, 1'b1, 100, 2, 3, 12, 1'b0, "R2");
      // R7 and R8: span exceeds length, tail from tap 0, saturates at 31
      run_sweep(1'b0, 1'b0, 0, 0, 200, 20, 1'b0, "R7");
      run_sweep(1'b0, 1'b0, 0, 0, 200, 20, 1'b0, "");
      // R7: overlap, flat region wins over tail
      run_sweep(1'b0, 1'b0, 4, 1, 100, 3, 1'b0, "R7");
      // R10: mid-sweep changes ignored
      run_sweep(1'b0, 1'b0, 2, 1, 10, 8, 1'b1, "R10");

      check(tap_valid == 1'b0 && done == 1'b0, "R9", "idle after last sweep",
            int'(tap_valid) + int'(done), 0);
      check(exp_q.size() == 0, "R2", "expected items left", exp_q.size(), 0);
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule